// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock

This core keeps wall-clock time as a 32-bit count of seconds. It runs from a system clock and receives the crystal oscillator as a one-cycle enable strobe, `xtal_tick`, at about 33.33 kHz. A prescaler counts these strobes against a programmable calibration word. When the programmed count is reached, it raises a one-second event. An optional fractional correction adds one tick to some seconds in each block of sixteen, which trims the long-run rate.

Software works through a small register port. Writes take effect at the clock edge, and reads return data combinationally on the same cycle. A new time written to the set register does not appear in the current-time register at once. It is loaded at the next second event. The seconds status bit tells software whether that load has happened yet. Writing the calibration word restarts the prescaler, so the next second ends exactly one calibrated period after the write.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the registers read as follows: current time 0, set readback 0, calibration 0x198233, status 0, control 0.
- R2: With fractional correction off, a second event occurs after every N+1 crystal ticks, where N is calibration bits [15:0]. Cycles without `xtal_tick` do not advance the count.
- R3: When calibration bit 20 is set, bits [19:16] give F. The second counter cycles through indices 0 to 15, and each second whose index is below F lasts one extra tick.
- R4: A write to the calibration register (offset 0x08) clears the tick count and the fractional index. The next second event then comes after a full calibrated period. A tick that arrives in the same cycle as the write is discarded.
- R5: At each second event, current time (offset 0x10) loads the pending set value if a set write is outstanding, and otherwise increments by one. Between events it holds its value.
- R6: Offset 0x04 reads back the last value written to the set register (offset 0x00).
- R7: Status bit 0 (offset 0x20) goes to 1 on each second event. Writing 1 to that bit clears it, and if an event occurs in the same cycle the event wins. `sec_irq` mirrors the bit.
- R8: Control (offset 0x40) holds only bit 31, which is read/write. All other control bits read as 0.
- R9: Reads of unmapped offsets and of offset 0x00 return 0. Writes to offsets 0x04 and 0x10, and to unmapped offsets, change no state.
- R10: `sec_pulse` is high for exactly the one cycle in which the new current time is first visible after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sec_irq | output | 1 | Seconds status bit |
| sec_pulse | output | 1 | One-cycle pulse after each second event |

## Verification
A wrong tick count or fractional index first shows as a second event one or more ticks early or late. Because `sec_pulse` and the current-time value are compared cycle by cycle, the error is caught at the edge where it first happens, not after time has drifted. A lost pending flag shows at the first event after a set write: the current time goes up by one where the set value was expected. A status bit with the wrong priority shows on the cycle after an event that coincides with a clear write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [6:0] OFS_SET_WR  = 7'h00;
  localparam logic [6:0] OFS_SET_RB  = 7'h04;
  localparam logic [6:0] OFS_CAL     = 7'h08;
  localparam logic [6:0] OFS_NOW     = 7'h10;
  localparam logic [6:0] OFS_STATUS  = 7'h20;
  localparam logic [6:0] OFS_CTRL    = 7'h40;

  localparam int CAL_W  = 21;
  localparam int CNT_W  = 16;
  localparam int FRAC_W = 4;

  // terminal tick count for the second with fractional index idx
  function automatic logic [CNT_W:0] sec_limit(input logic [CAL_W-1:0] cal,
                                               input logic [FRAC_W-1:0] idx);
    logic [CNT_W:0] base;
    logic           extra;
    base  = {1'b0, cal[CNT_W-1:0]};
    extra = cal[CAL_W-1] && (idx < cal[CNT_W+FRAC_W-1:CNT_W]);
    return base + {{CNT_W{1'b0}}, extra};
  endfunction

  function automatic logic [31:0] next_time(input logic [31:0] now,
                                            input logic pend,
                                            input logic [31:0] setv);
    return pend ? setv : now + 32'd1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             restart,
  input  logic [CAL_W-1:0] cal,
  output logic             sec_evt
);
  logic [CNT_W:0]    cnt_q;
  logic [FRAC_W-1:0] idx_q;
  logic [CNT_W:0]    limit;

  assign limit   = sec_limit(cal, idx_q);
  assign sec_evt = xtal_tick && !restart && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (xtal_tick) begin
      if (sec_evt) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r2_evt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> xtal_tick);
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && idx_q == '0));
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xtal_tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt,
  input  logic              set_wr,
  input  logic [TIME_W-1:0] set_data,
  output logic [TIME_W-1:0] now_q,
  output logic [TIME_W-1:0] set_q,
  output logic              pend_q,
  output logic              pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q   <= '0;
      set_q   <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= sec_evt;
      if (sec_evt) now_q <= next_time(now_q, pend_q, set_q);
      if (set_wr) begin
        set_q  <= set_data;
        pend_q <= 1'b1;
      end else if (sec_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !pend_q) |=> now_q == $past(now_q) + 1'b1);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && pend_q) |=> now_q == $past(set_q));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_evt |=> $stable(now_q));
  a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> pulse_q);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter logic [CAL_W-1:0] CAL_RESET = 21'h198233
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             sec_evt,
  input  logic [31:0]      now_q,
  input  logic [31:0]      set_q,
  output logic [CAL_W-1:0] cal_q,
  output logic             cal_wr,
  output logic             set_wr,
  output logic             sts_q,
  output logic [31:0]      bus_rdata
);
  logic ctl_q;
  logic sts_clr;

  assign cal_wr  = bus_wr && (bus_addr == OFS_CAL);
  assign set_wr  = bus_wr && (bus_addr == OFS_SET_WR);
  assign sts_clr = bus_wr && (bus_addr == OFS_STATUS) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= CAL_RESET;
      sts_q <= 1'b0;
      ctl_q <= 1'b0;
    end else begin
      if (cal_wr) cal_q <= bus_wdata[CAL_W-1:0];
      if (sec_evt) sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
      if (bus_wr && bus_addr == OFS_CTRL) ctl_q <= bus_wdata[31];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_SET_RB: bus_rdata = set_q;
      OFS_CAL:    bus_rdata = {{(32-CAL_W){1'b0}}, cal_q};
      OFS_NOW:    bus_rdata = now_q;
      OFS_STATUS: bus_rdata = {31'b0, sts_q};
      OFS_CTRL:   bus_rdata = {ctl_q, 31'b0};
      default:    bus_rdata = 32'b0;
    endcase
  end

  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> sts_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !sec_evt) |=> !sts_q);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter logic [CAL_W-1:0] CAL_RESET = 21'h198233
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_tick,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sec_irq,
  output logic        sec_pulse
);
  logic             sec_evt;
  logic             cal_wr;
  logic             set_wr;
  logic             pend_q;
  logic [CAL_W-1:0] cal_q;
  logic [31:0]      now_q;
  logic [31:0]      set_q;

  rtc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick),
    .restart(cal_wr), .cal(cal_q), .sec_evt(sec_evt)
  );

  rtc_timekeeper #(.TIME_W(32)) u_time (
    .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt),
    .set_wr(set_wr), .set_data(bus_wdata),
    .now_q(now_q), .set_q(set_q), .pend_q(pend_q), .pulse_q(sec_pulse)
  );

  rtc_regs #(.CAL_RESET(CAL_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sec_evt(sec_evt), .now_q(now_q), .set_q(set_q),
    .cal_q(cal_q), .cal_wr(cal_wr), .set_wr(set_wr), .sts_q(sec_irq),
    .bus_rdata(bus_rdata)
  );

  // R6: readback tracks the set register one cycle after a write
  a_r6_readback: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> set_q == $past(bus_wdata));
endmodule

// File: tb/sim_rtc_sec_core.sv
module sim_rtc_sec_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = 7'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sec_irq, sec_pulse;

  int checks = 0;
  int errors = 0;
  bit tick_auto = 1'b0;
  int tick_gap = 1;
  int gap_cnt = 0;

  // reference model state
  longint m_cnt, m_idx, m_cal, m_set, m_pend, m_now, m_sts, m_ctl, m_pulse;

  always #(CLK_P/2) clk = ~clk;

  rtc_sec_core u0 (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_irq(sec_irq), .sec_pulse(sec_pulse)
  );

  function automatic longint model_read(input int a);
    case (a)
      'h04: return m_set;
      'h08: return m_cal;
      'h10: return m_now;
      'h20: return m_sts;
      'h40: return m_ctl ? 64'h80000000 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: seconds are limit+1 ticks long
  always @(posedge clk) begin
    longint lim, n_cnt, n_idx, n_now, n_pend, n_sts;
    bit evt, cw;
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_cal = 'h198233; m_set = 0; m_pend = 0;
      m_now = 0; m_sts = 0; m_ctl = 0; m_pulse = 0;
    end else begin
      cw  = bus_wr && bus_addr == 'h08;
      lim = (m_cal % 65536);
      if (((m_cal >> 20) & 1) == 1 && m_idx < ((m_cal >> 16) & 15)) lim = lim + 1;
      evt = xtal_tick && !cw && (m_cnt >= lim);
      n_cnt = m_cnt; n_idx = m_idx; n_now = m_now; n_pend = m_pend; n_sts = m_sts;
      if (cw) begin n_cnt = 0; n_idx = 0; end
      else if (xtal_tick) begin
        if (evt) begin n_cnt = 0; n_idx = (m_idx + 1) % 16; end
        else n_cnt = m_cnt + 1;
      end
      if (evt) n_now = m_pend ? m_set : (m_now + 1) % 64'h100000000;
      if (bus_wr && bus_addr == 'h00) begin m_set = bus_wdata; n_pend = 1; end
      else if (evt) n_pend = 0;
      if (evt) n_sts = 1;
      else if (bus_wr && bus_addr == 'h20 && bus_wdata[0]) n_sts = 0;
      if (bus_wr && bus_addr == 'h40) m_ctl = bus_wdata[31];
      if (cw) m_cal = bus_wdata & 'h1FFFFF;
      m_cnt = n_cnt; m_idx = n_idx; m_now = n_now; m_pend = n_pend; m_sts = n_sts;
      m_pulse = evt;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R10 pulse", sec_pulse, m_pulse);
      check("R7 irq", sec_irq, m_sts);
      check("R9 rdata", bus_rdata, model_read(bus_addr));
    end
  end

  // crystal tick generator
  always @(negedge clk) begin
    if (tick_auto) begin
      gap_cnt++;
      if (gap_cnt >= tick_gap) begin xtal_tick <= 1'b1; gap_cnt = 0; end
      else xtal_tick <= 1'b0;
    end else xtal_tick <= 1'b0;
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 7'h10;
  endtask

  task automatic rd_check(input logic [6:0] a, input longint exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_addr = 7'h10;
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      while (!sec_pulse) begin @(posedge clk); #2; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check(7'h10, 0, "R1 now");
    rd_check(7'h04, 0, "R1 setrb");
    rd_check(7'h08, 'h198233, "R1 cal");
    rd_check(7'h20, 0, "R1 status");
    rd_check(7'h40, 0, "R1 ctrl");
    // R9 unmapped and write-only reads
    rd_check(7'h0C, 0, "R9 unmapped");
    rd_check(7'h00, 0, "R9 setwr read");
    // R8 control bit 31 only
    wr(7'h40, 32'hFFFF_FFFF);
    rd_check(7'h40, 'h80000000, "R8 ctrl set");
    wr(7'h40, 32'h7FFF_FFFF);
    rd_check(7'h40, 0, "R8 ctrl clr");
    // R2 plain calibration, N=4, ticks every cycle then every third
    wr(7'h08, 32'h0000_0004);
    rd_check(7'h08, 4, "R4 cal readback");
    tick_auto = 1'b1; tick_gap = 1;
    wait_pulses(3);
    tick_gap = 3;
    wait_pulses(3);
    check("R2 now count", bus_rdata, m_now);
    // R6 / R5 set time pending
    wr(7'h00, 32'd1000);
    rd_check(7'h04, 1000, "R6 readback");
    wait_pulses(1);
    #1 check("R5 loaded", bus_rdata, 1000);
    wait_pulses(2);
    #1 check("R5 incr", bus_rdata, 1002);
    // R7 clear by W1C
    wr(7'h20, 32'h1);
    // R9 writes to read-only offsets
    wr(7'h10, 32'h1234);
    wr(7'h04, 32'h5555);
    wr(7'h1C, 32'hFFFF);
    rd_check(7'h04, 1000, "R9 ro readback");
    // R4 calibration write mid-second with ticks every cycle
    tick_gap = 1;
    repeat (2) @(negedge clk);
    wr(7'h08, 32'h0000_0006);
    wait_pulses(2);
    // R3 fractional correction N=2, F=5
    wr(7'h08, (32'h1 << 20) | (32'h5 << 16) | 32'h2);
    wait_pulses(36);
    // R7 event and clear collide: keep issuing clears while ticking
    for (int i = 0; i < 40; i++) wr(7'h20, 32'h1);
    tick_auto = 1'b0;
    repeat (4) @(negedge clk);
    rd_check(7'h20, m_sts, "R7 status");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule